// File: doc/BRIEF.md
# Self-Healing Triple-Redundant Sequencer

This block holds three copies of a small W-bit sequencer. Each copy has its own clock, reset, enable and upset input, so no one wire or gate is shared by more than one domain. Before any copy computes its next state, its own private majority voter combines the three current states bit by bit. A copy whose register has been corrupted therefore picks up the agreed value on its very next clock edge and rejoins the other two without outside help. Each domain keeps its own voter, so a fault in one voter touches only one domain.

Each domain drives one output copy through its own minority voter. That voter compares the domain's state with the other two. When the domain disagrees with both, the voter drops that copy's drive enable, and the pad buffer fed by the data and enable pair goes to high impedance. The three output copies are joined on the board, outside the block.

A per-domain upset strobe, with its own value bus, overwrites one domain's register on one edge. This lets a test model a single-event upset.

Top module: `tmr_voted_seq`

## Requirements
- R1: While any reset is low and directly after the resets are released, every domain holds RESET_VAL (default 0), every `q_o` copy equals it and all three bits of `oe_o` are 1.
- R2: At an edge where a domain's enable is 1 and its upset strobe is 0, it loads the step of the bitwise 2-of-3 vote (a&b)|(a&c)|(b&c) of the three states. With the default binary variant, the step is vote + STEP (default 1) modulo 2^W, so 15 wraps to 0 for W=4.
- R3: At an edge where a domain's enable is 0 and its upset strobe is 0, it loads the vote unchanged, so an agreeing set of domains holds its value.
- R4: While one domain is upset, the other two domains keep the correct sequence on their `q_o` copies with their enables at 1.
- R5: At an edge where `upset_i[d]` is 1, domain d loads `upset_val_i[d*W +: W]`, and its `q_o[d*W +: W]` shows that value after the edge.
- R6: `oe_o[d]` is 0 exactly when domain d's state differs from both other states. Otherwise it is 1. A forced value that equals the correct state keeps the enable at 1.
- R7: After the first edge at which all upset strobes are 0 following a single-domain upset, all three states are equal and all enables are 1, whether the enable is high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 3 | One clock per domain |
| rst_ni | input | 3 | Active-low asynchronous reset per domain |
| en_i | input | 3 | Step enable, one copy per domain |
| upset_i | input | 3 | Per-domain register overwrite strobe |
| upset_val_i | input | 3*W | Overwrite value, slice d for domain d |
| q_o | output | 3*W | Output data copies, slice d from domain d |
| oe_o | output | 3 | Per-copy pad drive enable from the minority voters |

## Verification
The clocked properties take for granted that all three clocks, resets and enables carry the same value, and that no more than one upset strobe is high in any cycle. Only under those conditions do the resync, single-release and majority-kept properties hold. The bench drives each triplicated input from one value and picks at most one domain per cycle to upset. Some of these upsets come on consecutive edges in different domains, and some carry a value equal to the correct state, so both enable outcomes of the minority voter are reached.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int TMR_WAYS = 3;

   typedef enum logic {
      SEQ_BINARY  = 1'b0,
      SEQ_JOHNSON = 1'b1
   } seq_kind_e;

endpackage

// File: rtl/tmr_maj_vote.sv
module tmr_maj_vote #(
   parameter int W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] y_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("tmr_maj_vote: W must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign y_o[i] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
   end

   // Any two agreeing inputs must win the vote (R2).
   always_comb begin
      if (a_i == b_i) begin
         assert_vote_pair_ab_R2: assert (y_o == a_i);
      end
      if (b_i == c_i) begin
         assert_vote_pair_bc_R2: assert (y_o == b_i);
      end
   end

endmodule

// File: rtl/tmr_step.sv
module tmr_step
   import tmr_pkg::*;
#(
   parameter int        W        = 4,
   parameter int        STEP     = 1,
   parameter seq_kind_e SEQ_KIND = SEQ_BINARY
) (
   input  logic [W-1:0] cur_i,
   output logic [W-1:0] nxt_o
);

   generate
      if (SEQ_KIND == SEQ_BINARY) begin : g_binary
         localparam logic [W-1:0] INC = W'(STEP);
         assign nxt_o = cur_i + INC;
      end else begin : g_johnson
         always_comb begin
            nxt_o = cur_i;
            for (int k = 0; k < STEP; k++) begin
               nxt_o = {nxt_o[W-2:0], ~nxt_o[W-1]};
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tmr_minority.sv
module tmr_minority #(
   parameter int W = 4
) (
   input  logic [W-1:0] own_i,
   input  logic [W-1:0] peer_a_i,
   input  logic [W-1:0] peer_b_i,
   output logic         oe_o
);

   logic agree_a;
   logic agree_b;

   assign agree_a = (own_i == peer_a_i);
   assign agree_b = (own_i == peer_b_i);
   assign oe_o    = agree_a | agree_b;

endmodule

// File: rtl/tmr_domain.sv
module tmr_domain
   import tmr_pkg::*;
#(
   parameter int           W         = 4,
   parameter int           STEP      = 1,
   parameter seq_kind_e    SEQ_KIND  = SEQ_BINARY,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         en_i,
   input  logic         upset_i,
   input  logic [W-1:0] upset_val_i,
   input  logic [W-1:0] st_a_i,
   input  logic [W-1:0] st_b_i,
   input  logic [W-1:0] st_c_i,
   output logic [W-1:0] st_q_o
);

   logic [W-1:0] voted;
   logic [W-1:0] stepped;
   logic [W-1:0] nxt;

   // Private voter at the origin of this domain's feedback loop.
   tmr_maj_vote #(.W(W)) u_vote (
      .a_i (st_a_i),
      .b_i (st_b_i),
      .c_i (st_c_i),
      .y_o (voted)
   );

   tmr_step #(.W(W), .STEP(STEP), .SEQ_KIND(SEQ_KIND)) u_step (
      .cur_i (voted),
      .nxt_o (stepped)
   );

   assign nxt = en_i ? stepped : voted;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q_o <= RESET_VAL;
      end else if (upset_i) begin
         st_q_o <= upset_val_i;
      end else begin
         st_q_o <= nxt;
      end
   end

   // An upset strobe lands its value in this register (R5).
   assert_upset_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upset_i |=> (st_q_o == $past(upset_val_i)));

endmodule

// File: rtl/tmr_voted_seq.sv
module tmr_voted_seq
   import tmr_pkg::*;
#(
   parameter int           W         = 4,
   parameter int           STEP      = 1,
   parameter seq_kind_e    SEQ_KIND  = SEQ_BINARY,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic [2:0]     clk_i,
   input  logic [2:0]     rst_ni,
   input  logic [2:0]     en_i,
   input  logic [2:0]     upset_i,
   input  logic [3*W-1:0] upset_val_i,
   output logic [3*W-1:0] q_o,
   output logic [2:0]     oe_o
);

   localparam int N = TMR_WAYS;

   generate
      if (W < 2) begin : g_bad_w
         $error("tmr_voted_seq: W must be at least 2");
      end
      if (STEP < 1 || STEP > 2 * W) begin : g_bad_step
         $error("tmr_voted_seq: STEP out of range");
      end
      if (N != 3) begin : g_bad_ways
         $error("tmr_voted_seq: exactly three domains are supported");
      end
   endgenerate

   logic [W-1:0] st [N];

   for (genvar d = 0; d < N; d++) begin : g_dom
      localparam int PA = (d + 1) % N;
      localparam int PB = (d + 2) % N;

      tmr_domain #(
         .W         (W),
         .STEP      (STEP),
         .SEQ_KIND  (SEQ_KIND),
         .RESET_VAL (RESET_VAL)
      ) u_dom (
         .clk_i       (clk_i[d]),
         .rst_ni      (rst_ni[d]),
         .en_i        (en_i[d]),
         .upset_i     (upset_i[d]),
         .upset_val_i (upset_val_i[d*W +: W]),
         .st_a_i      (st[0]),
         .st_b_i      (st[1]),
         .st_c_i      (st[2]),
         .st_q_o      (st[d])
      );

      tmr_minority #(.W(W)) u_minor (
         .own_i    (st[d]),
         .peer_a_i (st[PA]),
         .peer_b_i (st[PB]),
         .oe_o     (oe_o[d])
      );

      assign q_o[d*W +: W] = st[d];
   end

   logic all_rst_n;
   logic all_eq;
   assign all_rst_n = &rst_ni;
   assign all_eq    = (st[0] == st[1]) && (st[1] == st[2]);

   // First edge with no strobe restores agreement (R7).
   assert_resync_R7: assert property (@(posedge clk_i[0]) disable iff (!all_rst_n)
      (upset_i == 3'b000) |=> all_eq);

   // Only a single copy is ever released (R6).
   assert_single_release_R6: assert property (@(posedge clk_i[0]) disable iff (!all_rst_n)
      $onehot0(upset_i) |=> ($countones(oe_o) >= 2));

   // Two domains always keep a common value (R4).
   assert_majority_kept_R4: assert property (@(posedge clk_i[0]) disable iff (!all_rst_n)
      $onehot0(upset_i) |=> ((st[0] == st[1]) || (st[1] == st[2]) || (st[0] == st[2])));

   // Agreeing domains with enable low keep their value (R3).
   assert_hold_R3: assert property (@(posedge clk_i[0]) disable iff (!all_rst_n)
      (en_i == 3'b000 && upset_i == 3'b000 && all_eq) |=> $stable(q_o));

   generate
      if (SEQ_KIND == SEQ_BINARY) begin : g_chk_bin
         // Agreeing domains with enable high advance by STEP (R2).
         assert_step_R2: assert property (@(posedge clk_i[0]) disable iff (!all_rst_n)
            (en_i == 3'b111 && upset_i == 3'b000 && all_eq)
            |=> (st[0] == $past(st[0]) + W'(STEP)));
      end
   endgenerate

endmodule

// File: tb/tb_tmr_voted_seq.sv
module tb_tmr_voted_seq;

   localparam int W = 4;

   logic             clk;
   logic [2:0]       rst_n;
   logic [2:0]       en;
   logic [2:0]       upset;
   logic [3*W-1:0]   upset_val;
   logic [3*W-1:0]   q;
   logic [2:0]       oe;

   int checks;
   int errors;

   logic [W-1:0] exp_st;
   logic         prev_forced;

   tmr_voted_seq #(.W(W)) dut (
      .clk_i       ({3{clk}}),
      .rst_ni      (rst_n),
      .en_i        (en),
      .upset_i     (upset),
      .upset_val_i (upset_val),
      .q_o         (q),
      .oe_o        (oe)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic logic [W-1:0] next_exp(logic [W-1:0] cur, logic step_en);
      return step_en ? cur + W'(1) : cur;
   endfunction

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One clock: drive at negedge, model at posedge, check at next negedge.
   task automatic step(logic step_en, int fd, logic [W-1:0] fv);
      string req;
      en        = {3{step_en}};
      upset     = (fd < 3) ? 3'(1 << fd) : 3'b000;
      upset_val = {3{fv}};
      @(posedge clk);
      exp_st = next_exp(exp_st, step_en);
      @(negedge clk);
      if (fd < 3)           req = "R4";
      else if (prev_forced) req = "R7";
      else if (step_en)     req = "R2";
      else                  req = "R3";
      for (int d = 0; d < 3; d++) begin
         if (d == fd) begin
            check("R5", $sformatf("q%0d", d), int'(q[d*W +: W]), int'(fv));
            check("R6", $sformatf("oe%0d", d), int'(oe[d]), int'(fv == exp_st));
         end else begin
            check(req, $sformatf("q%0d", d), int'(q[d*W +: W]), int'(exp_st));
            check(req, $sformatf("oe%0d", d), int'(oe[d]), 1);
         end
      end
      prev_forced = (fd < 3);
      upset = 3'b000;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unused_seed;
      checks      = 0;
      errors      = 0;
      exp_st      = '0;
      prev_forced = 1'b0;
      rst_n       = 3'b000;
      en          = 3'b000;
      upset       = 3'b000;
      upset_val   = '0;
      unused_seed = $urandom(32'h5EED_0007);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      for (int d = 0; d < 3; d++) begin
         check("R1", "q in reset", int'(q[d*W +: W]), 0);
         check("R1", "oe in reset", int'(oe[d]), 1);
      end
      rst_n = 3'b111;
      @(negedge clk);
      check("R1", "q after release", int'(q[W-1:0]), 0);

      // R3: hold with enable low
      repeat (3) step(1'b0, 3, '0);
      // R2: count up through the wrap from 15 to 0
      repeat (18) step(1'b1, 3, '0);
      // R5/R6 distinct value in domain 0, then R7 resync while counting
      step(1'b1, 0, exp_st + 4'd7);
      step(1'b1, 3, '0);
      // R6: forced value equals correct next state, enable stays high
      step(1'b1, 1, exp_st + 4'd1);
      step(1'b1, 3, '0);
      // R7: repair while enable is low
      step(1'b0, 2, ~exp_st);
      step(1'b0, 3, '0);
      // R4: back-to-back upsets in different domains
      step(1'b1, 0, 4'hF ^ exp_st);
      step(1'b1, 2, 4'h5 ^ exp_st);
      step(1'b1, 1, 4'h9 ^ exp_st);
      step(1'b1, 3, '0);

      // Constrained random: at most one domain upset per cycle
      for (int n = 0; n < 300; n++) begin
         logic se;
         int   fd;
         se = ($urandom % 4) != 0;
         fd = (($urandom % 5) == 0) ? int'($urandom % 3) : 3;
         step(se, fd, W'($urandom));
      end
      step(1'b1, 3, '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule